// File: doc/BRIEF.md
# Second-Order Counter-Based Decimation Filter

This block turns a one-bit stream, sampled on every clock, into multi-bit samples at a lower rate. It is a second-order cascaded integrator-comb decimator with no multipliers. The first integrator is a free-running counter that adds the input bit on every clock and is never cleared. A second counter adds the first counter's value on every clock and is read and cleared on the same edge whenever the decimation strobe is high. That single counter therefore does three jobs: the second integration, the rate change and the first comb stage.

The spacing between strobes sets the decimation ratio. The remaining comb stage can be built in, selected by a parameter. It subtracts the previous period sum from the current one. Without it, the raw period sums are output and that subtraction is left to slower downstream logic. All counters wrap modulo 2^ACC_W, where ACC_W = 1 + 2*LOG2_RATIO. Because the comb subtraction is exact modulo that width, wraparound inside the integrators cancels.

Top module: `cic2_decim`

## Requirements
- R1: While reset is asserted and after its release until the first strobe, `sample_out` is 0 and `sample_valid` is 0.
- R2: The first integrator adds `bit_in` (1 counts as one, 0 as nothing) on every clock, including strobe clocks, and wraps modulo 2^ACC_W. An all-ones input therefore produces period sums that grow and wrap.
- R3: On a clock edge where `dec_strobe` is high, the period sum is captured. The period sum is the sum, over every edge from the previous strobe edge (or from reset) up to but excluding this one, of the first-integrator value after that edge, taken modulo 2^ACC_W. The bit sampled on the strobe edge is counted into the new period.
- R4: With USE_COMB=1, the captured value is the current period sum minus the previous period sum, modulo 2^ACC_W. `sample_out` carries its upper OUT_W bits, bits [ACC_W-1 : ACC_W-OUT_W].
- R5: With USE_COMB=0, `sample_out` carries the upper OUT_W bits of the period sum itself.
- R6: `sample_valid` is high for exactly the one cycle after a strobe edge. It rises only from the second strobe after reset with USE_COMB=0, and only from the third strobe with USE_COMB=1.
- R7: `sample_out` holds its value between strobes.
- R8: Any strobe spacing from 1 clock up to 2^LOG2_RATIO is supported, including strobes on consecutive clocks, and may change from one period to the next.
- R9: With USE_COMB=1, a constant strobe spacing D ≤ 2^LOG2_RATIO and an all-ones input, every valid output equals D*D exactly, despite wraparound in both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | One-bit input sample, taken on every clock |
| dec_strobe | input | 1 | Closes the current decimation period on this edge |
| sample_out | output | OUT_W | Decimated sample, held between strobes |
| sample_valid | output | 1 | One-cycle pulse marking a valid new sample |

## Verification
The bench builds two copies with LOG2_RATIO=4, so ACC_W is 9 bits. One copy has the built-in comb and full-width output. The other has the raw period sum cut to its upper 7 bits, which brings output truncation into play. With a 9-bit width, the first integrator wraps within a few hundred clocks of all-ones input, and the raw period sums wrap within a single period. Wrap cancellation, the exact D*D result at the largest spacing of 16, and spacings down to one clock are all reached in about a thousand cycles.

// File: rtl/cic2_pkg.sv
package cic2_pkg;

  // Counter width that lets a second-order comb cancel wraparound
  // for a one-bit input and a ratio of at most 2**log2_ratio.
  function automatic int acc_width(input int log2_ratio);
    return 2 * log2_ratio + 1;
  endfunction

  // Number of strobes that must have passed before an output is trusted.
  function automatic int strobes_before_valid(input bit use_comb);
    return use_comb ? 2 : 1;
  endfunction

  // Modular difference of two period sums (the comb step).
  function automatic logic [63:0] comb_diff(input logic [63:0] cur,
                                            input logic [63:0] prev);
    return cur - prev;
  endfunction

endpackage

// File: rtl/cic2_integ1.sv
// First integrator: a bit-sliced counter that adds a one-bit input every
// clock. Slice 0 takes the input as its carry; every other slice only
// ripples the carry from the slice below.
module cic2_integ1 #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  output logic [W-1:0] i1_next
);

  logic [W-1:0] i1_q;
  logic [W-1:0] carry;
  logic         armed_q;

  assign carry[0] = bit_in;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_slice
      assign i1_next[b] = i1_q[b] ^ carry[b];
      if (b < W - 1) begin : g_carry
        assign carry[b+1] = i1_q[b] & carry[b];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i1_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      i1_q    <= i1_next;
      armed_q <= 1'b1;
    end
  end

  // R2
  integ1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (i1_q == $past(i1_q) + W'($past(bit_in))));

endmodule

// File: rtl/cic2_dump_acc.sv
// Second counter: accumulates the first integrator every clock and is
// read and restarted on the dump edge (second integration, rate change
// and first comb stage in one register).
module cic2_dump_acc #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dump,
  input  logic [W-1:0] add_val,
  output logic [W-1:0] acc_q
);

  logic [W-1:0] acc_next;
  logic         armed_q;

  always_comb begin
    if (dump) acc_next = add_val;
    else      acc_next = acc_q + add_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      acc_q   <= acc_next;
      armed_q <= 1'b1;
    end
  end

  // R3
  dump_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(dump)) |-> (acc_q == $past(add_val)));

  // R3
  accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(dump)) |-> (acc_q == $past(acc_q) + $past(add_val)));

endmodule

// File: rtl/cic2_out_stage.sv
// Output stage: optional final comb, truncation to the output width and
// the valid pulse gated by the number of strobes since reset.
module cic2_out_stage #(
  parameter int W        = 19,
  parameter int OUT_W    = 15,
  parameter bit USE_COMB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dump,
  input  logic [W-1:0]     period_sum,
  output logic [OUT_W-1:0] out_q,
  output logic             valid_q
);

  localparam int NEED = cic2_pkg::strobes_before_valid(USE_COMB);

  logic [W-1:0] out_full;
  logic [1:0]   cnt_q;
  logic         armed_q;
  logic         unused_low;
  logic [63:0]  diff64;

  generate
    if (USE_COMB) begin : g_comb
      logic [W-1:0] prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n)    prev_q <= '0;
        else if (dump) prev_q <= period_sum;
      end
      assign diff64   = cic2_pkg::comb_diff(64'(period_sum), 64'(prev_q));
      assign out_full = diff64[W-1:0];
    end else begin : g_raw
      assign diff64   = 64'(period_sum);
      assign out_full = period_sum;
    end
  endgenerate

  assign unused_low = ^{out_full, diff64};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      valid_q <= dump && (cnt_q >= 2'(NEED));
      if (dump) begin
        out_q <= out_full[W-1 -: OUT_W];
        if (cnt_q < 2'(NEED)) cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  // R6
  valid_after_dump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && valid_q) |-> $past(dump));

  // R6
  early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(dump) && ($past(cnt_q) < 2'(NEED))) |-> !valid_q);

  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(dump)) |-> $stable(out_q));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> ((out_q == '0) && !valid_q));

endmodule

// File: rtl/cic2_decim.sv
module cic2_decim #(
  parameter int LOG2_RATIO = 9,
  parameter bit USE_COMB   = 1'b1,
  parameter int OUT_W      = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             dec_strobe,
  output logic [OUT_W-1:0] sample_out,
  output logic             sample_valid
);

  localparam int ACC_W = cic2_pkg::acc_width(LOG2_RATIO);

  logic [ACC_W-1:0] i1_next;
  logic [ACC_W-1:0] period_acc;
  logic             dump_evt;

  assign dump_evt = dec_strobe;

  cic2_integ1 #(.W(ACC_W)) u_integ1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (bit_in),
    .i1_next (i1_next)
  );

  cic2_dump_acc #(.W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .dump    (dump_evt),
    .add_val (i1_next),
    .acc_q   (period_acc)
  );

  cic2_out_stage #(.W(ACC_W), .OUT_W(OUT_W), .USE_COMB(USE_COMB)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .dump       (dump_evt),
    .period_sum (period_acc),
    .out_q      (sample_out),
    .valid_q    (sample_valid)
  );

endmodule

// File: tb/cic2_decim_tb.sv
module cic2_decim_tb_top;

  localparam int L      = 4;
  localparam int W      = 2 * L + 1;
  localparam int OW_RAW = W - 2;
  localparam int MAXN   = 4096;
  localparam int MAXS   = 512;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n  = 1'b0;
  logic              bit_in = 1'b0;
  logic              strb   = 1'b0;
  logic [W-1:0]      c_out;
  logic              c_val;
  logic [OW_RAW-1:0] r_out;
  logic              r_val;

  cic2_decim #(.LOG2_RATIO(L), .USE_COMB(1'b1), .OUT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .dec_strobe(strb),
    .sample_out(c_out), .sample_valid(c_val));

  cic2_decim #(.LOG2_RATIO(L), .USE_COMB(1'b0), .OUT_W(OW_RAW)) dut_raw_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .dec_strobe(strb),
    .sample_out(r_out), .sample_valid(r_val));

  int total = 0;
  int bad   = 0;
  int pref  [MAXN];
  int sedge [MAXS];
  int nstr  = 0;
  int n     = 0;
  int cycles = 0;
  string raw_tag = "R3";
  bit ones_phase = 1'b0;
  logic [W-1:0]      c_last = '0;
  logic [OW_RAW-1:0] r_last = '0;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, n);
    end
  endtask

  // Sum of first-integrator values over the edges of period k.
  function automatic longint period_sum(input int k);
    int     first;
    longint s;
    first = (k == 1) ? 0 : sedge[k-1];
    s = 0;
    for (int m = first; m < sedge[k]; m++) s += longint'(pref[m]);
    return s;
  endfunction

  function automatic longint wmask(input longint v);
    return v & ((longint'(1) << W) - 1);
  endfunction

  task automatic eval_edge(input bit was_strobe);
    int k;
    if (was_strobe) begin
      k = nstr;
      check("R6 raw valid", longint'(r_val), longint'(k >= 2));
      check("R6 comb valid", longint'(c_val), longint'(k >= 3));
      if (k >= 2)
        check({raw_tag, " R5 raw value"}, longint'(r_out),
              wmask(period_sum(k)) >> (W - OW_RAW));
      if (k >= 3) begin
        check("R4 comb value", longint'(c_out),
              wmask(period_sum(k) - period_sum(k-1)));
        if (ones_phase) check("R9 all-ones", longint'(c_out), 256);
      end
      c_last = c_out;
      r_last = r_out;
    end else begin
      check("R6 no valid", longint'(c_val) + longint'(r_val), 0);
      check("R7 comb hold", longint'(c_out), longint'(c_last));
      check("R7 raw hold", longint'(r_out), longint'(r_last));
    end
  endtask

  task automatic cyc(input bit x, input bit s);
    bit_in = x;
    strb   = s;
    pref[n] = ((n == 0) ? 0 : pref[n-1]) + int'(x);
    if (s) begin
      nstr++;
      sedge[nstr] = n;
    end
    @(negedge clk);
    eval_edge(s);
    n++;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=%0d expected<=%0d", cycles, 50000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 comb out", longint'(c_out), 0);
    check("R1 raw out", longint'(r_out), 0);
    check("R1 valids", longint'(c_val) + longint'(r_val), 0);
    rst_n = 1'b1;

    // R2 / R9: all-ones input, spacing 16, counters wrap
    raw_tag = "R2";
    ones_phase = 1'b1;
    for (int i = 0; i < 176; i++) cyc(1'b1, (n % 16) == 15);
    ones_phase = 1'b0;

    // R3: random bits, fixed spacing 16
    raw_tag = "R3";
    for (int i = 0; i < 400; i++) cyc(1'($urandom_range(0, 1)), (n % 16) == 15);

    // R8: random spacing 1..16
    raw_tag = "R8";
    for (int p = 0; p < 40; p++) begin
      int g;
      g = $urandom_range(1, 16);
      for (int j = 0; j < g - 1; j++) cyc(1'($urandom_range(0, 1)), 1'b0);
      cyc(1'($urandom_range(0, 1)), 1'b1);
    end

    // R8: strobes on consecutive clocks
    for (int i = 0; i < 8; i++) cyc(1'($urandom_range(0, 1)), 1'b1);

    // R3: all-zeros input, integrator holds its level
    raw_tag = "R3";
    for (int i = 0; i < 64; i++) cyc(1'b0, (i % 16) == 15);

    // R7: quiet tail, outputs hold
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule